// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line in one private first-level cache of a multicore system in which all caches watch a shared bus. Each line is always in one of four states: Modified, Exclusive, Shared or Invalid. The processor side issues one read or write at a time. The block completes the access at once when the current state allows it. Otherwise it requests the bus, waits for a grant and issues one of three transactions: read-shared, read-exclusive or upgrade. The upgrade transaction invalidates the other copies of the line.

The block also watches transactions that the other caches place on the bus. For each one it reports whether it holds the line and whether its copy is dirty, and it then downgrades or drops its own copy. Lines are 64 bytes, so the low six address bits never take part. A direct index selects the line. Data storage, tags, replacement and memory are handled elsewhere. Several copies of the block share one bus, and an external arbiter grants that bus to one copy at a time.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and all outputs are low. States are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3. Bus commands are encoded none=0, read-shared=1, read-exclusive=2, upgrade=3.
- R2: A read to an Invalid line issues read-shared. The line ends in Exclusive when `bus_shared` is low in the grant cycle, and in Shared when it is high.
- R3: A Shared line never becomes Exclusive. A local read hit or a snooped read-shared leaves it Shared.
- R4: A write to a Shared line first issues an upgrade on the bus and only then becomes Modified. Peers that hold the line move to Invalid.
- R5: A write to an Exclusive line becomes Modified with no bus transaction.
- R6: A write to an Invalid line issues read-exclusive and ends in Modified.
- R7: A snooped read-shared that hits a Modified line raises `snp_hit` and `snp_dirty` and leaves the line Shared. A hit on an Exclusive line raises only `snp_hit` and leaves the line Shared.
- R8: A snooped read-exclusive or upgrade that hits a valid line raises `snp_hit` and sets the line to Invalid. It also raises `snp_dirty` when the line was Modified.
- R9: `bus_req` stays high until `bus_gnt` arrives. `bus_valid` is high only in the grant cycle. `bus_addr` then carries the line address with bits [5:0] zero.
- R10: `cpu_done` is a one-cycle pulse. `cpu_state` gives the line state after the access. A read hit, or a write to a Modified line, completes with no bus transaction.
- R11: The line index is taken from `cpu_addr[6 +: IDX_W]` and `snp_addr[6 +: IDX_W]`. Accesses that differ only in bits [5:0] reach the same line.
- R12: The bus command is chosen from the line state in the grant cycle. A write that waited on a Shared line which a peer invalidated meanwhile issues read-exclusive instead of upgrade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_valid | input | 1 | Processor access request, held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_state | output | 2 | Line state after the completed access |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | This cache drives a transaction in this cycle |
| bus_cmd | output | 2 | Transaction command |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_shared | input | 1 | OR of the peers' hit responses in the grant cycle |
| snp_valid | input | 1 | A peer drives a transaction on the bus |
| snp_cmd | input | 2 | The peer's command |
| snp_addr | input | ADDR_W | The peer's line address |
| snp_hit | output | 1 | This cache holds the snooped line |
| snp_dirty | output | 1 | This cache holds the snooped line Modified |

## Verification
The assertions assume the arbiter grants only a cache that is requesting and grants the bus to one cache per cycle. They also assume `snp_valid` is never high while this cache itself owns the bus. In addition, they rely on the processor keeping its request steady until `cpu_done`. The bench builds the bus from a fixed-priority arbiter over two caches and feeds each cache's snoop inputs from the other cache's bus outputs. It releases each request only after the completion pulse. As a result, every snoop the bench produces comes from a real peer transaction, and no two caches ever drive the bus at once.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RDS  = 2'd1,
    BC_RDX  = 2'd2,
    BC_UPG  = 2'd3
  } bcmd_e;

  typedef enum logic {
    F_IDLE = 1'b0,
    F_WAIT = 1'b1
  } fsm_e;

  localparam int LINE_OFS = 6;

endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
  import coh_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDX_W  = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_W-1:0]         rd_a_idx,
  output mesi_e                    rd_a_st,
  input  logic [IDX_W-1:0]         rd_b_idx,
  output mesi_e                    rd_b_st,
  input  logic                     snp_we,
  input  logic [IDX_W-1:0]         snp_idx,
  input  mesi_e                    snp_st,
  input  logic                     loc_we,
  input  logic [IDX_W-1:0]         loc_idx,
  input  mesi_e                    loc_st,
  output mesi_e [NLINES-1:0]       lines_o
);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    mesi_e line_d;
    mesi_e line_q;
    logic  line_en;

    always_comb begin
      line_d  = line_q;
      line_en = 1'b0;
      if (snp_we && (snp_idx == IDX_W'(g))) begin
        line_d  = snp_st;
        line_en = 1'b1;
      end else if (loc_we && (loc_idx == IDX_W'(g))) begin
        line_d  = loc_st;
        line_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q <= ST_I;
      end else if (line_en) begin
        line_q <= line_d;
      end
    end

    assign lines_o[g] = line_q;

    AST_S_NEVER_E: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q == ST_S) |=> (line_q != ST_E)); // R3
  end

  assign rd_a_st = lines_o[rd_a_idx];
  assign rd_b_st = lines_o[rd_b_idx];

  AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_we && loc_we && (snp_idx == loc_idx))); // R8

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
(
  input  logic  snp_valid,
  input  bcmd_e snp_cmd,
  input  mesi_e line_st,
  output logic  hit,
  output logic  dirty,
  output logic  we,
  output mesi_e nxt_st
);

  always_comb begin
    hit    = snp_valid && (snp_cmd != BC_NONE) && (line_st != ST_I);
    dirty  = hit && (line_st == ST_M);
    we     = 1'b0;
    nxt_st = line_st;
    if (hit) begin
      unique case (snp_cmd)
        BC_RDS: begin
          if (line_st != ST_S) begin
            we     = 1'b1;
            nxt_st = ST_S;
          end
        end
        BC_RDX, BC_UPG: begin
          we     = 1'b1;
          nxt_st = ST_I;
        end
        default: begin
          we     = 1'b0;
          nxt_st = line_st;
        end
      endcase
    end
  end

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [LINE_W-1:0] cpu_line,
  input  logic              block,
  input  mesi_e             line_st,
  output logic [IDX_W-1:0]  look_idx,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  output logic              bus_req,
  output logic              bus_valid,
  output bcmd_e             bus_cmd,
  output logic [LINE_W-1:0] bus_line,
  output logic              loc_we,
  output logic [IDX_W-1:0]  loc_idx,
  output mesi_e             loc_st,
  output logic              cpu_done,
  output mesi_e             cpu_state
);

  fsm_e              fsm_q, fsm_d;
  logic [LINE_W-1:0] pend_line_q;
  logic              pend_wr_q;
  logic              pend_ld;
  logic              done_q, done_d;
  mesi_e             rsp_q, rsp_d;

  always_comb begin
    fsm_d     = fsm_q;
    pend_ld   = 1'b0;
    done_d    = 1'b0;
    rsp_d     = rsp_q;
    loc_we    = 1'b0;
    loc_st    = line_st;
    bus_req   = 1'b0;
    bus_valid = 1'b0;
    bus_cmd   = BC_NONE;
    look_idx  = (fsm_q == F_WAIT) ? pend_line_q[IDX_W-1:0] : cpu_line[IDX_W-1:0];
    loc_idx   = look_idx;
    unique case (fsm_q)
      F_IDLE: begin
        if (cpu_valid && !done_q && !block) begin
          if (!cpu_write && (line_st != ST_I)) begin
            done_d = 1'b1;
            rsp_d  = line_st;
          end else if (cpu_write && (line_st == ST_M)) begin
            done_d = 1'b1;
            rsp_d  = ST_M;
          end else if (cpu_write && (line_st == ST_E)) begin
            loc_we = 1'b1;
            loc_st = ST_M;
            done_d = 1'b1;
            rsp_d  = ST_M;
          end else begin
            pend_ld = 1'b1;
            fsm_d   = F_WAIT;
          end
        end
      end
      F_WAIT: begin
        bus_req = 1'b1;
        if (pend_wr_q) begin
          bus_cmd = (line_st == ST_S) ? BC_UPG : BC_RDX;
        end else begin
          bus_cmd = BC_RDS;
        end
        if (bus_gnt) begin
          bus_valid = 1'b1;
          loc_we    = 1'b1;
          if (pend_wr_q) begin
            loc_st = ST_M;
          end else begin
            loc_st = bus_shared ? ST_S : ST_E;
          end
          done_d = 1'b1;
          rsp_d  = loc_st;
          fsm_d  = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      done_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_line_q <= '0;
      pend_wr_q   <= 1'b0;
    end else if (pend_ld) begin
      pend_line_q <= cpu_line;
      pend_wr_q   <= cpu_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= ST_I;
    end else if (done_d) begin
      rsp_q <= rsp_d;
    end
  end

  assign bus_line  = pend_line_q;
  assign cpu_done  = done_q;
  assign cpu_state = rsp_q;

  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> $stable(bus_line)); // R9

  AST_READ_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_cmd == BC_RDS)) |=> (cpu_done && (cpu_state == ($past(bus_shared) ? ST_S : ST_E)))); // R2

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic [1:0]        cpu_state,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_dirty
);

  localparam int IDX_W  = $clog2(NLINES);
  localparam int LINE_W = ADDR_W - LINE_OFS;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic [LINE_W-1:0] cpu_line;
  logic [IDX_W-1:0]  snp_idx;
  logic              unused_addr_bits;

  assign cpu_line = cpu_addr[ADDR_W-1:LINE_OFS];
  assign snp_idx  = snp_addr[LINE_OFS +: IDX_W];
  assign unused_addr_bits = ^{cpu_addr[LINE_OFS-1:0], snp_addr[LINE_OFS-1:0],
                              snp_addr[ADDR_W-1:LINE_OFS+IDX_W]};

  mesi_e [NLINES-1:0] lines;
  mesi_e              look_st, snp_st_cur, snp_st_nxt, loc_st, rsp_st;
  logic [IDX_W-1:0]   look_idx, loc_idx;
  logic               snp_we, loc_we, block;
  bcmd_e              cmd_o;
  logic [LINE_W-1:0]  bus_line;

  assign block = snp_valid && (snp_idx == cpu_line[IDX_W-1:0]);

  coh_state_array #(
    .NLINES (NLINES),
    .IDX_W  (IDX_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_i),
    .rd_a_idx (look_idx),
    .rd_a_st  (look_st),
    .rd_b_idx (snp_idx),
    .rd_b_st  (snp_st_cur),
    .snp_we   (snp_we),
    .snp_idx  (snp_idx),
    .snp_st   (snp_st_nxt),
    .loc_we   (loc_we),
    .loc_idx  (loc_idx),
    .loc_st   (loc_st),
    .lines_o  (lines)
  );

  coh_snoop_unit u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bcmd_e'(snp_cmd)),
    .line_st   (snp_st_cur),
    .hit       (snp_hit),
    .dirty     (snp_dirty),
    .we        (snp_we),
    .nxt_st    (snp_st_nxt)
  );

  coh_req_fsm #(
    .LINE_W (LINE_W),
    .IDX_W  (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i),
    .cpu_valid  (cpu_valid),
    .cpu_write  (cpu_write),
    .cpu_line   (cpu_line),
    .block      (block),
    .line_st    (look_st),
    .look_idx   (look_idx),
    .bus_gnt    (bus_gnt),
    .bus_shared (bus_shared),
    .bus_req    (bus_req),
    .bus_valid  (bus_valid),
    .bus_cmd    (cmd_o),
    .bus_line   (bus_line),
    .loc_we     (loc_we),
    .loc_idx    (loc_idx),
    .loc_st     (loc_st),
    .cpu_done   (cpu_done),
    .cpu_state  (rsp_st)
  );

  assign bus_cmd   = cmd_o;
  assign bus_addr  = {bus_line, {LINE_OFS{1'b0}}};
  assign cpu_state = rsp_st;

  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_i)
    bus_gnt |-> bus_req); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_req && !bus_gnt) |=> bus_req); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_i)
    cpu_done |=> !cpu_done); // R10

  AST_SNP_KILL: assert property (@(posedge clk) disable iff (!rst_i)
    (snp_valid && ((snp_cmd == BC_RDX) || (snp_cmd == BC_UPG)))
      |=> (lines[$past(snp_idx)] == ST_I)); // R8

  AST_NO_SELF_SNOOP: assert property (@(posedge clk) disable iff (!rst_i)
    !(snp_valid && bus_valid)); // R9

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    AST_S_TO_M_BUS: assert property (@(posedge clk) disable iff (!rst_i)
      (lines[i] == ST_S) |=> ((lines[i] != ST_M) || ($past(bus_valid) && ($past(bus_cmd) == BC_UPG)))); // R4

    AST_E_TO_M_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
      (lines[i] == ST_E) |=> ((lines[i] != ST_M) || !$past(bus_valid))); // R5
  end

endmodule

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb;

  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              cv [2];
  logic              cw [2];
  logic [ADDR_W-1:0] ca [2];
  logic              done [2];
  logic [1:0]        cst [2];
  logic              req [2];
  logic              gnt [2];
  logic              bv [2];
  logic [1:0]        bc [2];
  logic [ADDR_W-1:0] ba [2];
  logic              hit [2];
  logic              dirty [2];

  always_comb begin
    gnt[1] = req[1];
    gnt[0] = req[0] && !req[1];
  end

  coh_line_ctrl #(.ADDR_W(ADDR_W), .NLINES(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[0]), .cpu_write(cw[0]), .cpu_addr(ca[0]),
    .cpu_done(done[0]), .cpu_state(cst[0]),
    .bus_req(req[0]), .bus_gnt(gnt[0]), .bus_valid(bv[0]),
    .bus_cmd(bc[0]), .bus_addr(ba[0]), .bus_shared(hit[1]),
    .snp_valid(bv[1]), .snp_cmd(bc[1]), .snp_addr(ba[1]),
    .snp_hit(hit[0]), .snp_dirty(dirty[0])
  );

  coh_line_ctrl #(.ADDR_W(ADDR_W), .NLINES(8)) u_peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[1]), .cpu_write(cw[1]), .cpu_addr(ca[1]),
    .cpu_done(done[1]), .cpu_state(cst[1]),
    .bus_req(req[1]), .bus_gnt(gnt[1]), .bus_valid(bv[1]),
    .bus_cmd(bc[1]), .bus_addr(ba[1]), .bus_shared(hit[0]),
    .snp_valid(bv[0]), .snp_cmd(bc[0]), .snp_addr(ba[0]),
    .snp_hit(hit[1]), .snp_dirty(dirty[1])
  );

  typedef struct {
    string             tag;
    logic [1:0]        st;
    logic [1:0]        cmd;
    logic              phit;
    logic              pdirty;
    logic [ADDR_W-1:0] line;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   errors = 0;
  int   checks = 0;

  task automatic chk(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [1:0]        sc [2];
  logic              sh [2];
  logic              sd [2];
  logic [ADDR_W-1:0] sa [2];

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        sc[c] = 2'd0; sh[c] = 1'b0; sd[c] = 1'b0; sa[c] = '0;
      end else begin
        if (bv[c]) begin
          sc[c] = bc[c];
          sh[c] = hit[1-c];
          sd[c] = dirty[1-c];
          sa[c] = ba[c];
        end
        if (done[c]) begin
          exp_t it;
          if ((c == 0 && q0.size() == 0) || (c == 1 && q1.size() == 0)) begin
            chk("R10 unexpected done", 32'd1, 32'd0);
          end else begin
            it = (c == 0) ? q0.pop_front() : q1.pop_front();
            chk({it.tag, " state"}, 32'(cst[c]), 32'(it.st));
            chk({it.tag, " bus cmd"}, 32'(sc[c]), 32'(it.cmd));
            chk({it.tag, " peer hit"}, 32'(sh[c]), 32'(it.phit));
            chk({it.tag, " peer dirty"}, 32'(sd[c]), 32'(it.pdirty));
            if (it.cmd != 2'd0) chk({it.tag, " R9 bus addr"}, sa[c], it.line);
          end
          sc[c] = 2'd0; sh[c] = 1'b0; sd[c] = 1'b0; sa[c] = '0;
        end
      end
    end
  end

  task automatic access(int c, bit wr, logic [ADDR_W-1:0] a, string tag,
                        logic [1:0] est, logic [1:0] ecmd, bit eh, bit ed);
    exp_t it;
    it.tag = tag; it.st = est; it.cmd = ecmd; it.phit = eh; it.pdirty = ed;
    it.line = {a[ADDR_W-1:6], 6'b0};
    if (c == 0) q0.push_back(it); else q1.push_back(it);
    @(negedge clk);
    cv[c] = 1'b1; cw[c] = wr; ca[c] = a;
    do @(negedge clk); while (!done[c]);
    cv[c] = 1'b0;
    @(negedge clk);
    chk({tag, " R10 done pulse"}, 32'(done[c]), 32'd0);
  endtask

  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
  localparam logic [1:0] NO = 2'd0, RDS = 2'd1, RDX = 2'd2, UPG = 2'd3;

  task automatic finish_run();
    chk("R10 scoreboard empty", 32'(q0.size() + q1.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      cv[c] = 1'b0; cw[c] = 1'b0; ca[c] = '0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R1 reset done", 32'(done[c]), 32'd0);
      chk("R1 reset req", 32'(req[c]), 32'd0);
      chk("R1 reset bus_valid", 32'(bv[c]), 32'd0);
      chk("R1 reset snp_hit", 32'(hit[c]), 32'd0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    access(0, 0, 32'h40, "R2 read miss alone", E, RDS, 0, 0);
    access(0, 1, 32'h40, "R5 write on E", M, NO, 0, 0);
    access(1, 0, 32'h40, "R7 snoop RDS on M", S, RDS, 1, 1);
    access(0, 0, 32'h43, "R11 R3 read hit S", S, NO, 0, 0);
    access(0, 1, 32'h40, "R4 write on S upgrade", M, UPG, 1, 0);
    access(1, 0, 32'h40, "R4 peer invalidated refetch", S, RDS, 1, 1);
    access(1, 1, 32'h80, "R6 write miss", M, RDX, 0, 0);
    access(0, 1, 32'h80, "R8 RDX hits M", M, RDX, 1, 1);
    access(1, 0, 32'h80, "R2 read shared fill", S, RDS, 1, 1);
    access(1, 0, 32'hC0, "R2 read miss E", E, RDS, 0, 0);
    access(0, 0, 32'hC0, "R7 snoop RDS on E", S, RDS, 1, 0);
    access(1, 0, 32'hC7, "R3 S kept after peer read", S, NO, 0, 0);
    access(0, 0, 32'h100, "R2 fill E", E, RDS, 0, 0);
    access(1, 1, 32'h100, "R8 RDX hits E", M, RDX, 1, 0);
    access(0, 0, 32'h13F, "R8 line was invalid", S, RDS, 1, 1);
    access(0, 1, 32'h140, "R6 write miss second", M, RDX, 0, 0);
    access(0, 1, 32'h141, "R10 write hit M", M, NO, 0, 0);

    fork
      access(1, 1, 32'hC0, "R4 race winner upgrade", M, UPG, 1, 0);
      access(0, 1, 32'hC0, "R12 race loser RDX", M, RDX, 1, 1);
    join
    access(1, 0, 32'hC0, "R12 winner lost line", S, RDS, 1, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule